// File: doc/BRIEF.md
# Keyed System Control Register File

This block is the control and status register set of a processor core module. A host reaches it over a simple register bus: one write strobe, a byte address whose two low bits must be zero, 32-bit write data, and 32-bit read data. Each register sits at a word index. Read data is registered, so it appears one cycle after the address is presented. Writes take effect at the clock edge where the strobe is sampled.

The block holds several kinds of state. Two clock-setting words accept writes only while a 16-bit unlock key sits in the lock word. A control word drives a status LED and selects the boot memory map: remap low keeps boot flash at address zero, remap high lets RAM appear there. The same control word issues a one-cycle reset request. Two flag words are changed through separate set and clear aliases. A 32-bit reference counter advances on a tick enable taken from the 24 MHz reference. A small interrupt source has a software-settable bit 0, separate IRQ and FIQ enable masks, and registered IRQ and FIQ lines.

The size of the attached memory, in megabytes, is a parameter. It selects the size field held in the memory-configuration word at reset.

Top module: `sysctl_regfile`

## Requirements
- R1: On reset the registers take these values: clock word 0x01000048, auxiliary clock word 0x0007FEFF, init word 0x00000112, memory-configuration word 0x00011122 ORed with 0x10, 0x0C, 0x08 or 0x04 for at least 256, 128, 64 or 32 MB (nothing below 32 MB). Lock, control, both flag words, the counter, the enables and the soft interrupt reset to zero, as do all outputs.
- R2: Index 0 reads 0x411A3001, index 1 reads 0 and index 4 reads 0x00100000. Writes to these indices change nothing.
- R3: A write to index 5 stores only bits [15:0] of the write data. A read of index 5 returns 0x0001A05F while the stored key is 0xA05F, and otherwise returns the stored 16 bits zero-extended.
- R4: Writes to the clock word (index 2) and the auxiliary clock word (index 7) are taken only while the stored key is 0xA05F. Otherwise they are ignored.
- R5: A write to the control word (index 3) stores bit 0 (LED) and bit 2 (remap). A read returns those two bits with every other bit zero. led_o and remap_o show the stored bits from the cycle after the write.
- R6: A control write with bit 3 set raises rst_req_o for exactly the one cycle after the write. rst_req_o is low at all other times.
- R7: A write to index 12 ORs the data into the flag word, and a write to index 13 clears the bits that are set in the data. Indices 14 and 15 do the same for the second flag word. Indices 12 and 14 read the words, and indices 13 and 15 read zero.
- R8: The counter at index 10 increments by one, wrapping at 32 bits, in each cycle where tick_i is high. Writes to index 10 are ignored.
- R9: The interrupt source has these indices:
  - 17 and 25 read the raw level. Only bit 0, the soft bit, can be set.
  - 18 and 26 read the IRQ and FIQ enables. Writes to them OR the data into the enables.
  - 19 and 27 clear the enable bits that are set in the data.
  - 16 and 24 read the raw level ANDed with the IRQ and FIQ enables.
  - A write to 20 with bit 0 set sets the soft bit, and a write to 21 with bit 0 set clears it.
  - Index 20 reads the soft bit.
- R10: irq_o and fiq_o are high one cycle after the raw level ANDed with the IRQ or FIQ enable, respectively, is nonzero.
- R11: Any index not listed above reads zero and ignores writes. So does any access with addr_i[1:0] nonzero.
- R12: rdata_o presents the word addressed in one cycle at the following clock edge.
- R13: The memory-configuration word (index 8) and the init word (index 9) are stored in full on any write, without regard to the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Reference tick enable for the counter |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address; word index in bits [ADDR_W-1:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | One-cycle reset request |
| remap_o | output | 1 | High selects RAM at address zero |
| led_o | output | 1 | Status LED drive |
| irq_o | output | 1 | Masked IRQ request |
| fiq_o | output | 1 | Masked FIQ request |

## Verification
Every stored bit is visible on a read one cycle after its address is presented, and the bench compares all 64 indices against a model after every write of a full sweep. A corrupted register, a wrong decode or a leaked write therefore shows at rdata_o no later than the read pass that follows the faulty write. A bad key comparison or bad write gating leaves a clock word that differs from the model in that same pass. A wrong enable or soft-bit state shows on irq_o or fiq_o two edges after the write. A counter fault shows as a count offset after a known number of ticks.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;

  // word indices (decoded by software, so fixed)
  localparam logic [31:0] IX_ID      = 32'd0;
  localparam logic [31:0] IX_PROC    = 32'd1;
  localparam logic [31:0] IX_OSC     = 32'd2;
  localparam logic [31:0] IX_CTRL    = 32'd3;
  localparam logic [31:0] IX_STAT    = 32'd4;
  localparam logic [31:0] IX_LOCK    = 32'd5;
  localparam logic [31:0] IX_AUX     = 32'd7;
  localparam logic [31:0] IX_SDRAM   = 32'd8;
  localparam logic [31:0] IX_INIT    = 32'd9;
  localparam logic [31:0] IX_RCNT    = 32'd10;
  localparam logic [31:0] IX_FLG_S   = 32'd12;
  localparam logic [31:0] IX_FLG_C   = 32'd13;
  localparam logic [31:0] IX_NVF_S   = 32'd14;
  localparam logic [31:0] IX_NVF_C   = 32'd15;
  localparam logic [31:0] IX_IRQ_ST  = 32'd16;
  localparam logic [31:0] IX_RAW_A   = 32'd17;
  localparam logic [31:0] IX_IEN_S   = 32'd18;
  localparam logic [31:0] IX_IEN_C   = 32'd19;
  localparam logic [31:0] IX_SW_S    = 32'd20;
  localparam logic [31:0] IX_SW_C    = 32'd21;
  localparam logic [31:0] IX_FIQ_ST  = 32'd24;
  localparam logic [31:0] IX_RAW_B   = 32'd25;
  localparam logic [31:0] IX_FEN_S   = 32'd26;
  localparam logic [31:0] IX_FEN_C   = 32'd27;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [31:0] ID_VAL     = 32'h411A_3001;
  localparam logic [31:0] STAT_VAL   = 32'h0010_0000;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;

  // control word bit positions
  localparam int CB_LED   = 0;
  localparam int CB_REMAP = 2;
  localparam int CB_RST   = 3;

  function automatic logic [31:0] sdram_rst(input int mem_mb);
    logic [31:0] sz;
    if (mem_mb >= 256)      sz = 32'h10;
    else if (mem_mb >= 128) sz = 32'h0C;
    else if (mem_mb >= 64)  sz = 32'h08;
    else if (mem_mb >= 32)  sz = 32'h04;
    else                    sz = 32'h00;
    return SDRAM_BASE | sz;
  endfunction
endpackage

// File: rtl/sysctl_gated_reg.sv
module sysctl_gated_reg #(
  parameter int          DW      = 32,
  parameter logic [DW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          allow,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)               q <= RST_VAL;
    else if (we && allow)  q <= wd;
  end
endmodule

// File: rtl/sysctl_setclr_reg.sv
module sysctl_setclr_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_we,
  input  logic          clr_we,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_we) q <= q | wd;
    else if (clr_we) q <= q & ~wd;
  end
endmodule

// File: rtl/sysctl_irq_src.sv
module sysctl_irq_src #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ien_set_we,
  input  logic          ien_clr_we,
  input  logic          fen_set_we,
  input  logic          fen_clr_we,
  input  logic          sw_set_we,
  input  logic          sw_clr_we,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] raw,
  output logic [DW-1:0] ien,
  output logic [DW-1:0] fen,
  output logic          irq_o,
  output logic          fiq_o
);
  logic soft_q;

  sysctl_setclr_reg #(.DW(DW)) u_ien (
    .clk(clk), .rst(rst), .set_we(ien_set_we), .clr_we(ien_clr_we),
    .wd(wd), .q(ien));

  sysctl_setclr_reg #(.DW(DW)) u_fen (
    .clk(clk), .rst(rst), .set_we(fen_set_we), .clr_we(fen_clr_we),
    .wd(wd), .q(fen));

  always_ff @(posedge clk) begin
    if (rst)                     soft_q <= 1'b0;
    else if (sw_set_we && wd[0]) soft_q <= 1'b1;
    else if (sw_clr_we && wd[0]) soft_q <= 1'b0;
  end

  assign raw = {{(DW-1){1'b0}}, soft_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |(raw & ien);
      fiq_o <= |(raw & fen);
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int MEM_MB = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rst_req_o,
  output logic              remap_o,
  output logic              led_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int IDX_W = ADDR_W - 2;
  localparam int NKEY  = 4;
  localparam int NSC   = 2;

  localparam logic [31:0]   KIX   [NKEY] = '{IX_OSC, IX_AUX, IX_SDRAM, IX_INIT};
  localparam logic [DW-1:0] KRST  [NKEY] = '{OSC_RST, AUX_RST, sdram_rst(MEM_MB), INIT_RST};
  localparam bit            KGATE [NKEY] = '{1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [31:0]   SIX   [NSC]  = '{IX_FLG_S, IX_NVF_S};
  localparam logic [31:0]   CIX   [NSC]  = '{IX_FLG_C, IX_NVF_C};

  logic            aligned;
  logic [31:0]     idx32;
  logic            wr_ok;
  logic [15:0]     lock_q;
  logic            unlocked;
  logic [DW-1:0]   keyed_q [NKEY];
  logic [DW-1:0]   sc_q    [NSC];
  logic [DW-1:0]   cnt_q;
  logic            led_q, remap_q;
  logic [DW-1:0]   raw_w, ien_w, fen_w;
  logic [DW-1:0]   rd_next;

  assign aligned  = (addr_i[1:0] == 2'b00);
  assign idx32    = 32'(addr_i[ADDR_W-1:2]);
  assign wr_ok    = wr_en_i && aligned;
  assign unlocked = (lock_q == UNLOCK_KEY);

  // lock key
  always_ff @(posedge clk) begin
    if (rst)                          lock_q <= '0;
    else if (wr_ok && idx32 == IX_LOCK) lock_q <= wdata_i[15:0];
  end

  // plain and key-gated words
  for (genvar g = 0; g < NKEY; g++) begin : g_word
    sysctl_gated_reg #(.DW(DW), .RST_VAL(KRST[g])) u_word (
      .clk(clk), .rst(rst),
      .we(wr_ok && idx32 == KIX[g]),
      .allow(KGATE[g] ? unlocked : 1'b1),
      .wd(wdata_i), .q(keyed_q[g]));
  end

  // flag words with set/clear aliases
  for (genvar g = 0; g < NSC; g++) begin : g_flag
    sysctl_setclr_reg #(.DW(DW)) u_flag (
      .clk(clk), .rst(rst),
      .set_we(wr_ok && idx32 == SIX[g]),
      .clr_we(wr_ok && idx32 == CIX[g]),
      .wd(wdata_i), .q(sc_q[g]));
  end

  // control word and reset pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= wr_ok && idx32 == IX_CTRL && wdata_i[CB_RST];
      if (wr_ok && idx32 == IX_CTRL) begin
        led_q   <= wdata_i[CB_LED];
        remap_q <= wdata_i[CB_REMAP];
      end
    end
  end
  assign led_o   = led_q;
  assign remap_o = remap_q;

  // reference counter
  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  sysctl_irq_src #(.DW(DW)) u_irq (
    .clk(clk), .rst(rst),
    .ien_set_we(wr_ok && idx32 == IX_IEN_S),
    .ien_clr_we(wr_ok && idx32 == IX_IEN_C),
    .fen_set_we(wr_ok && idx32 == IX_FEN_S),
    .fen_clr_we(wr_ok && idx32 == IX_FEN_C),
    .sw_set_we (wr_ok && idx32 == IX_SW_S),
    .sw_clr_we (wr_ok && idx32 == IX_SW_C),
    .wd(wdata_i), .raw(raw_w), .ien(ien_w), .fen(fen_w),
    .irq_o(irq_o), .fiq_o(fiq_o));

  // read mux
  always_comb begin
    rd_next = '0;
    if (aligned) begin
      case (idx32)
        IX_ID:     rd_next = ID_VAL;
        IX_OSC:    rd_next = keyed_q[0];
        IX_CTRL:   rd_next = {28'b0, 1'b0, remap_q, 1'b0, led_q};
        IX_STAT:   rd_next = STAT_VAL;
        IX_LOCK:   rd_next = unlocked ? {15'b0, 1'b1, lock_q} : {16'b0, lock_q};
        IX_AUX:    rd_next = keyed_q[1];
        IX_SDRAM:  rd_next = keyed_q[2];
        IX_INIT:   rd_next = keyed_q[3];
        IX_RCNT:   rd_next = cnt_q;
        IX_FLG_S:  rd_next = sc_q[0];
        IX_NVF_S:  rd_next = sc_q[1];
        IX_IRQ_ST: rd_next = raw_w & ien_w;
        IX_RAW_A:  rd_next = raw_w;
        IX_IEN_S:  rd_next = ien_w;
        IX_SW_S:   rd_next = raw_w & 32'h1;
        IX_FIQ_ST: rd_next = raw_w & fen_w;
        IX_RAW_B:  rd_next = raw_w;
        IX_FEN_S:  rd_next = fen_w;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_next;
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [15:0]       lock_q,
  input logic [31:0]       osc,
  input logic [31:0]       flags,
  input logic [31:0]       cnt,
  input logic [31:0]       raw,
  input logic [31:0]       ien,
  input logic [31:0]       fen
);
  logic [31:0] ix;
  logic        wr;
  assign ix = 32'(addr_i[ADDR_W-1:2]);
  assign wr = wr_en_i && (addr_i[1:0] == 2'b00);

  AST_LOCK_LOW16: assert property (@(posedge clk) disable iff (rst)
    (wr && ix == IX_LOCK) |=> lock_q == $past(wdata_i[15:0])) else $error("lock"); // R3
  AST_OSC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr && ix == IX_OSC && lock_q != UNLOCK_KEY) |=> $stable(osc)) else $error("osc locked"); // R4
  AST_OSC_OPEN: assert property (@(posedge clk) disable iff (rst)
    (wr && ix == IX_OSC && lock_q == UNLOCK_KEY) |=> osc == $past(wdata_i)) else $error("osc open"); // R4
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wr && ix == IX_CTRL && wdata_i[CB_RST]) |=> rst_req_o) else $error("rst pulse"); // R6
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(wr && ix == IX_CTRL && wdata_i[CB_RST]) |=> !rst_req_o) else $error("rst quiet"); // R6
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    (wr && ix == IX_FLG_S) |=> (flags & $past(wdata_i)) == $past(wdata_i)) else $error("flag set"); // R7
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(cnt)) else $error("cnt hold"); // R8
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> cnt == $past(cnt) + 32'd1) else $error("cnt step"); // R8
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
    (|(raw & ien)) |=> irq_o) else $error("irq on"); // R10
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & ien)) |=> !irq_o) else $error("irq off"); // R10
  AST_FIQ_ON: assert property (@(posedge clk) disable iff (rst)
    (|(raw & fen)) |=> fiq_o) else $error("fiq on"); // R10
  AST_FIQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !(|(raw & fen)) |=> !fiq_o) else $error("fiq off"); // R10
endmodule

bind sysctl_regfile sysctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rst_req_o(rst_req_o), .irq_o(irq_o), .fiq_o(fiq_o),
  .lock_q(lock_q), .osc(keyed_q[0]), .flags(sc_q[0]), .cnt(cnt_q),
  .raw(raw_w), .ien(ien_w), .fen(fen_w));

// File: tb/sysctl_regfile_bench.sv
module sysctl_regfile_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int MEM_MB = 128;
  localparam int NW = 1 << (ADDR_W - 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic rst_req_o, remap_o, led_o, irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  // model state
  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flg, m_nvf, m_cnt, m_ien, m_fen;
  logic [15:0] m_lock;
  logic m_led, m_remap, m_soft;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_regfile #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB)) u_sysctl_regfile (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .rst_req_o(rst_req_o),
    .remap_o(remap_o), .led_o(led_o), .irq_o(irq_o), .fiq_o(fiq_o));

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  endtask

  task automatic ck(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int ix);
    case (ix)
      0, 1, 4:  return "R2";
      2, 7:     return "R4";
      3:        return "R5";
      5:        return "R3";
      8, 9:     return "R13";
      10:       return "R8";
      12, 13, 14, 15: return "R7";
      16, 17, 18, 19, 20, 21, 24, 25, 26, 27: return "R9";
      default:  return "R11";
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input int ix);
    logic [31:0] raw;
    raw = {31'b0, m_soft};
    case (ix)
      0:  return 32'h411A_3001;
      2:  return m_osc;
      3:  return {29'b0, m_remap, 1'b0, m_led};
      4:  return 32'h0010_0000;
      5:  return (m_lock == 16'hA05F) ? 32'h0001_A05F : {16'b0, m_lock};
      7:  return m_aux;
      8:  return m_sdram;
      9:  return m_init;
      10: return m_cnt;
      12: return m_flg;
      14: return m_nvf;
      16: return raw & m_ien;
      17, 25: return raw;
      18: return m_ien;
      20: return raw;
      24: return raw & m_fen;
      26: return m_fen;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void mdl_wr(input int ix, input logic [31:0] d);
    case (ix)
      2:  if (m_lock == 16'hA05F) m_osc = d;
      3:  begin m_led = d[0]; m_remap = d[2]; end
      5:  m_lock = d[15:0];
      7:  if (m_lock == 16'hA05F) m_aux = d;
      8:  m_sdram = d;
      9:  m_init = d;
      12: m_flg = m_flg | d;
      13: m_flg = m_flg & ~d;
      14: m_nvf = m_nvf | d;
      15: m_nvf = m_nvf & ~d;
      18: m_ien = m_ien | d;
      19: m_ien = m_ien & ~d;
      20: if (d[0]) m_soft = 1'b1;
      21: if (d[0]) m_soft = 1'b0;
      26: m_fen = m_fen | d;
      27: m_fen = m_fen & ~d;
      default: ;
    endcase
  endfunction

  // write one word; checks the reset-request pulse (R6) just after the edge
  task automatic wr(input int ix, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = ADDR_W'(ix << 2); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    mdl_wr(ix, d);
    ck("R6", "rst_req after write", {31'b0, rst_req_o}, {31'b0, (ix == 3 && d[3])});
  endtask

  // one-cycle read latency (R12)
  task automatic rd(input int ix, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr_i = ADDR_W'(ix << 2);
    @(negedge clk);
    ck(tag, $sformatf("read idx %0d (R12)", ix), rdata_o, exp);
  endtask

  task automatic ck_outs();
    @(negedge clk);
    ck("R5", "led_o", {31'b0, led_o}, {31'b0, m_led});
    ck("R5", "remap_o", {31'b0, remap_o}, {31'b0, m_remap});
    ck("R6", "rst_req idle", {31'b0, rst_req_o}, 32'h0);
    ck("R10", "irq_o", {31'b0, irq_o}, {31'b0, m_soft & m_ien[0]});
    ck("R10", "fiq_o", {31'b0, fiq_o}, {31'b0, m_soft & m_fen[0]});
  endtask

  task automatic rd_all();
    for (int i = 0; i < NW; i++) rd(i, exp_rd(i), tag_of(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    m_osc = 32'h0100_0048; m_aux = 32'h0007_FEFF; m_init = 32'h0000_0112;
    m_sdram = 32'h0001_1122 | (MEM_MB >= 256 ? 32'h10 : MEM_MB >= 128 ? 32'h0C :
                               MEM_MB >= 64 ? 32'h08 : MEM_MB >= 32 ? 32'h04 : 32'h0);
    m_flg = 0; m_nvf = 0; m_cnt = 0; m_ien = 0; m_fen = 0; m_lock = 0;
    m_led = 0; m_remap = 0; m_soft = 0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of all words and outputs
    ck("R1", "rdata after reset", rdata_o, 32'h0);
    ck_outs();
    for (int i = 0; i < NW; i++) rd(i, exp_rd(i), "R1");
    rd(8, 32'h0001_112E, "R1");

    // R3/R4: key behaviour
    wr(2, 32'hDEAD_0001);
    rd(2, 32'h0100_0048, "R4");
    wr(5, 32'h0007_A05F);
    rd(5, 32'h0001_A05F, "R3");
    wr(2, 32'h1234_5678);
    rd(2, 32'h1234_5678, "R4");
    wr(7, 32'h0BAD_F00D);
    rd(7, 32'h0BAD_F00D, "R4");
    wr(5, 32'h0000_A05E);
    rd(5, 32'h0000_A05E, "R3");
    wr(7, 32'h1111_1111);
    rd(7, 32'h0BAD_F00D, "R4");

    // R5/R6: control word
    wr(3, 32'hFFFF_FFFF);
    rd(3, 32'h0000_0005, "R5");
    ck_outs();
    wr(3, 32'h0000_0008);
    rd(3, 32'h0000_0000, "R5");
    ck_outs();

    // R7: flag aliases
    wr(12, 32'h00F0_00F0);
    wr(12, 32'h0000_0F0F);
    rd(12, 32'h00F0_0FFF, "R7");
    wr(13, 32'h0000_00FF);
    rd(12, 32'h00F0_0F00, "R7");
    rd(13, 32'h0, "R7");
    wr(14, 32'h8000_0001);
    wr(15, 32'h0000_0001);
    rd(14, 32'h8000_0000, "R7");

    // R9/R10: interrupt source
    wr(20, 32'h1);
    rd(17, 32'h1, "R9");
    ck_outs();
    wr(18, 32'h0000_0003);
    ck_outs();
    rd(16, 32'h1, "R9");
    wr(26, 32'h1);
    ck_outs();
    rd(24, 32'h1, "R9");
    wr(19, 32'h1);
    ck_outs();
    rd(16, 32'h0, "R9");
    wr(21, 32'hFFFF_FFFE);
    rd(20, 32'h1, "R9");
    wr(21, 32'h1);
    ck_outs();
    rd(25, 32'h0, "R9");

    // R8: counter
    for (int i = 0; i < 37; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
    m_cnt = 37;
    rd(10, 32'd37, "R8");
    wr(10, 32'hFFFF_FFFF);
    rd(10, 32'd37, "R8");
    @(negedge clk); tick_i = 1'b1;
    repeat (1000) @(negedge clk);
    tick_i = 1'b0;
    m_cnt = 37 + 1000;
    rd(10, 32'd1037, "R8");

    // R11: misaligned access ignored and reads zero
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = ADDR_W'((9 << 2) | 1); wdata_i = 32'h5555_5555;
    @(negedge clk);
    wr_en_i = 1'b0;
    ck("R11", "misaligned read", rdata_o, 32'h0);
    rd(9, m_init, "R11");

    // sweep: every index written, then all indices compared (locked, then unlocked)
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) wr(5, 32'h0000_A05F);
      for (int i = 0; i < NW; i++) begin
        logic [31:0] d;
        d = (32'(i) * 32'h0101_0101) ^ 32'hA5C3_0F96 ^ (pass == 1 ? 32'hFFFF_FFFF : 32'h0);
        if (i == 5) d = (pass == 1) ? 32'hFFFF_A05F : 32'h1234_5678;
        wr(i, d);
        ck_outs();
        rd_all();
      end
    end

    report();
  end
endmodule